// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A register-mapped timer with a parameter number of independent channels. Each channel owns a 64-bit down-counter, an interval register, an enable, a 3-bit power-of-two prescaler and a one-shot select. A control write can copy the interval into the counter. When the counter is at zero and a prescaled tick arrives, the channel expires. A periodic channel then restarts from the interval. A one-shot channel clears its own enable and stays at zero.

Every expiry sets a sticky status bit. The status bit is set whether or not the channel's interrupt is enabled. Software clears it by writing a one to it. A single interrupt line is the OR of status AND enable over all channels. The bus is a simple select/write/address/data port whose ready is high in the same cycle as the select. Read data is combinational. The timer runs on the bus clock. An active-low reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `dcount_timer`

## Requirements
- R1: After reset every readable register reads 0, the interrupt output is low, and no channel runs.
- R2: The address map is: interrupt enable at 0x00 and status at 0x04. Channel n's base is 0x10+0x20*n; from that base, control is at +0x0, interval low/high at +0x4/+0x8, and count low/high at +0xC/+0x10. Unmapped addresses read 0. Ready equals select in the same cycle.
- R3: In the control word, bit 0 is enable, bit 1 is load, bits 6:4 are the prescale select, and bit 7 is one-shot. Bits 3:1 always read 0, so load reads back as 0.
- R4: A control write with bit 1 set copies the interval into the counter at that write. Interval writes alone leave the counter unchanged.
- R5: With prescale select N, a running counter takes one step every 2^N cycles. A control write restarts the prescale phase, so the first step after the write comes 2^N cycles later.
- R6: A step taken while the count is 0 is an expiry. In periodic mode (bit 7 = 0), an expiry reloads the interval, giving a period of (interval+1)*2^N cycles. A step taken while the count is not 0 decrements the count by 1.
- R7: In one-shot mode (bit 7 = 1), an expiry clears the enable bit and the count stays at 0.
- R8: Clearing the enable bit freezes the count from the cycle after the write. Setting enable again without load resumes from the frozen value.
- R9: An expiry sets status bit n even when interrupt enable bit n is 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: If a status clear and an expiry hit the same bit in the same cycle, the bit ends up set.
- R11: The interrupt output is high exactly when some channel has both its status bit and its enable bit set.
- R12: A channel loaded with all ones and running reads a falling count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_ready | output | 1 | Access complete, same cycle as select |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong count, enable or prescale phase inside a channel shows up on the next read of that channel's count or control word. It also shows up at the cycle the status bit should have set, because the expiry lands one or more cycles early or late. A wrong status or enable bit shows up on the interrupt line in the same cycle, and the bench compares that line every cycle. Reads of the count are compared against a cycle-stepped reference model, so a one-cycle slip in reload, prescale or stop timing is caught at the first read after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // prescale select width; divider depth follows from it
  localparam int unsigned PS_W  = 3;
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  // control word field positions (software visible)
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned LOAD_BIT = 1;
  localparam int unsigned DIV_LSB  = 4;
  localparam int unsigned OS_BIT   = 7;

  // global register offsets and per-channel window
  localparam int unsigned OFF_IEN    = 'h00;
  localparam int unsigned OFF_IST    = 'h04;
  localparam int unsigned CH_BASE    = 'h10;
  localparam int unsigned CH_STRIDE  = 'h20;
  localparam int unsigned CH_SPAN    = 'h14;

  typedef enum logic [2:0] {
    SLOT_CTL    = 3'd0,
    SLOT_IVL_LO = 3'd1,
    SLOT_IVL_HI = 3'd2,
    SLOT_CNT_LO = 3'd3,
    SLOT_CNT_HI = 3'd4
  } slot_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clear,
  input  logic [PS_W-1:0] sel,
  output logic            tick_o
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] mask;

  // low sel bits set: tick once per 2^sel cycles
  assign mask   = ~({DIV_W{1'b1}} << sel);
  assign tick_o = run && !clear && ((pcnt_q & mask) == mask);

  always_comb begin
    pcnt_d = pcnt_q + 1'b1;
    if (clear) pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt_q <= '0;
    else if (run || clear)  pcnt_q <= pcnt_d;
  end

  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_rd,
  output logic [CNT_W-1:0]  ival_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  logic            run_q, run_d;
  logic            os_q, os_d;
  logic [PS_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] ival_q, ival_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en, run_en, ival_en;
  logic            tick;
  logic            at_zero;

  tmr_prescaler u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .clear  (ctl_we || !run_q),
    .sel    (div_q),
    .tick_o (tick)
  );

  assign at_zero = (cnt_q == '0);

  // interval next state
  always_comb begin
    ival_d  = ival_q;
    ival_en = lo_we || hi_we;
    if (lo_we) ival_d[DATA_W-1:0]     = wdata;
    if (hi_we) ival_d[CNT_W-1:DATA_W] = wdata;
  end

  // control, count and expiry next state
  always_comb begin
    run_d    = run_q;
    os_d     = os_q;
    div_d    = div_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    run_en   = 1'b0;
    expire_o = 1'b0;
    if (ctl_we) begin
      run_en = 1'b1;
      run_d  = wdata[RUN_BIT];
      os_d   = wdata[OS_BIT];
      div_d  = wdata[DIV_LSB +: PS_W];
      if (wdata[LOAD_BIT]) begin
        cnt_en = 1'b1;
        cnt_d  = ival_q;
      end
    end else if (tick) begin
      cnt_en = 1'b1;
      if (at_zero) begin
        expire_o = 1'b1;
        if (os_q) begin
          run_en = 1'b1;
          run_d  = 1'b0;
          cnt_d  = cnt_q;
        end else begin
          cnt_d  = ival_q;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q  <= 1'b0;
      div_q <= '0;
    end else if (ctl_we) begin
      os_q  <= os_d;
      div_q <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ival_q <= '0;
    else if (ival_en) ival_q <= ival_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    ctl_rd                       = '0;
    ctl_rd[RUN_BIT]              = run_q;
    ctl_rd[DIV_LSB +: PS_W]      = div_q;
    ctl_rd[OS_BIT]               = os_q;
  end

  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wdata[LOAD_BIT]) |=> (cnt_q == $past(ival_q)));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !os_q) |=> (cnt_q == $past(ival_q)));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && os_q) |=> (!run_q && at_zero));

  // R8
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ien_we,
  input  logic           ist_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] ien_o,
  output logic [NCH-1:0] ist_o,
  output logic           irq_o
);
  logic [NCH-1:0] ien_q;
  logic [NCH-1:0] ist_q, ist_d;
  logic           ist_en;

  // clear first, then new expiries on top: a same-cycle expiry wins
  always_comb begin
    ist_d = ist_q;
    if (ist_we) ist_d = ist_d & ~wdata;
    ist_d  = ist_d | expire;
    ist_en = ist_we || (|expire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ist_q <= '0;
    else if (ist_en) ist_q <= ist_d;
  end

  assign ien_o = ien_q;
  assign ist_o = ist_q;
  assign irq_o = |(ist_q & ien_q);

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ist_we |=> ((ist_q & $past(wdata & ~expire)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((ist_q & $past(expire)) == $past(expire)));

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic                   wr_stb;
  logic [NCH-1:0]         ctl_we, lo_we, hi_we, expire;
  logic [NCH-1:0][DATA_W-1:0] ch_rd;
  logic [NCH-1:0]         ien, ist;
  logic                   ien_hit, ist_hit;

  assign wr_stb    = bus_sel && bus_wr;
  assign bus_ready = bus_sel;
  assign ien_hit   = (bus_addr == ADDR_W'(OFF_IEN));
  assign ist_hit   = (bus_addr == ADDR_W'(OFF_IST));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * n);
    logic [ADDR_W-1:0] rel;
    logic              in_win;
    slot_e             slot;
    logic [DATA_W-1:0] ctl_word;
    logic [CNT_W-1:0]  ival, cnt;

    assign rel    = bus_addr - BASE;
    assign in_win = (rel < ADDR_W'(CH_SPAN)) && (rel[1:0] == 2'b00);
    assign slot   = slot_e'(rel[4:2]);

    assign ctl_we[n] = wr_stb && in_win && (slot == SLOT_CTL);
    assign lo_we[n]  = wr_stb && in_win && (slot == SLOT_IVL_LO);
    assign hi_we[n]  = wr_stb && in_win && (slot == SLOT_IVL_HI);

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .ctl_we   (ctl_we[n]),
      .lo_we    (lo_we[n]),
      .hi_we    (hi_we[n]),
      .wdata    (bus_wdata),
      .ctl_rd   (ctl_word),
      .ival_o   (ival),
      .cnt_o    (cnt),
      .expire_o (expire[n])
    );

    always_comb begin
      ch_rd[n] = '0;
      if (in_win) begin
        case (slot)
          SLOT_CTL:    ch_rd[n] = ctl_word;
          SLOT_IVL_LO: ch_rd[n] = ival[DATA_W-1:0];
          SLOT_IVL_HI: ch_rd[n] = ival[CNT_W-1:DATA_W];
          SLOT_CNT_LO: ch_rd[n] = cnt[DATA_W-1:0];
          SLOT_CNT_HI: ch_rd[n] = cnt[CNT_W-1:DATA_W];
          default:     ch_rd[n] = '0;
        endcase
      end
    end
  end

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ien_we (wr_stb && ien_hit),
    .ist_we (wr_stb && ist_hit),
    .wdata  (bus_wdata[NCH-1:0]),
    .expire (expire),
    .ien_o  (ien),
    .ist_o  (ist),
    .irq_o  (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (ien_hit) bus_rdata = DATA_W'(ien);
    if (ist_hit) bus_rdata = DATA_W'(ist);
    for (int n = 0; n < NCH; n++) bus_rdata = bus_rdata | ch_rd[n];
  end

  // R2
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_sel |-> bus_ready);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !irq_o);
endmodule

// File: tb/dcount_timer_bench.sv
`timescale 1ns/1ps
module dcount_timer_bench;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, irq_o;

  always #2 clk = ~clk;

  dcount_timer u_dcount_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  // reference model, stepped from the requirements
  bit              m_run [NCH];
  bit              m_os  [NCH];
  bit [2:0]        m_div [NCH];
  bit [63:0]       m_ival[NCH];
  bit [63:0]       m_cnt [NCH];
  bit [6:0]        m_ph  [NCH];
  bit [NCH-1:0]    m_ien, m_ist;

  function automatic bit [7:0] chb(int n);
    return 8'(16 + 32 * n);
  endfunction

  task automatic model_reset();
    for (int n = 0; n < NCH; n++) begin
      m_run[n] = 0; m_os[n] = 0; m_div[n] = 0;
      m_ival[n] = 0; m_cnt[n] = 0; m_ph[n] = 0;
    end
    m_ien = '0; m_ist = '0;
  endtask

  task automatic model_step();
    bit wr;
    bit [NCH-1:0] ex;
    wr = bus_sel && bus_wr;
    ex = '0;
    for (int n = 0; n < NCH; n++) begin
      bit cw;
      bit [6:0] msk;
      bit tk;
      cw  = wr && (bus_addr == chb(n));
      msk = 7'((1 << m_div[n]) - 1);
      tk  = m_run[n] && !cw && ((m_ph[n] & msk) == msk);
      if (cw) begin
        m_run[n] = bus_wdata[0];
        m_os[n]  = bus_wdata[7];
        m_div[n] = bus_wdata[6:4];
        m_ph[n]  = 0;
        if (bus_wdata[1]) m_cnt[n] = m_ival[n];
      end else if (!m_run[n]) begin
        m_ph[n] = 0;
      end else begin
        m_ph[n] = m_ph[n] + 1;
        if (tk) begin
          if (m_cnt[n] == 0) begin
            ex[n] = 1'b1;
            if (m_os[n]) m_run[n] = 0;
            else         m_cnt[n] = m_ival[n];
          end else begin
            m_cnt[n] = m_cnt[n] - 1;
          end
        end
      end
      if (wr && bus_addr == chb(n) + 8'd4) m_ival[n][31:0]  = bus_wdata;
      if (wr && bus_addr == chb(n) + 8'd8) m_ival[n][63:32] = bus_wdata;
    end
    if (wr && bus_addr == 8'h00) m_ien = bus_wdata[NCH-1:0];
    if (wr && bus_addr == 8'h04) m_ist = m_ist & ~bus_wdata[NCH-1:0];
    m_ist = m_ist | ex;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a == 8'h00) return 32'(m_ien);
    if (a == 8'h04) return 32'(m_ist);
    for (int n = 0; n < NCH; n++) begin
      if (a == chb(n))         return {24'd0, m_os[n], m_div[n], 3'b000, m_run[n]};
      if (a == chb(n) + 8'd4)  return m_ival[n][31:0];
      if (a == chb(n) + 8'd8)  return m_ival[n][63:32];
      if (a == chb(n) + 8'd12) return m_cnt[n][31:0];
      if (a == chb(n) + 8'd16) return m_cnt[n][63:32];
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(bit [7:0] a);
    bit [7:0] r;
    if (a < 8'h10) return "R9";
    r = 8'((a - 8'h10) % 32);
    if (r == 0) return "R3";
    if (r == 4 || r == 8) return "R4";
    if (r == 12 || r == 16) return "R6";
    return "R2";
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // interrupt line compared every cycle against the model (R11)
  always @(negedge clk) begin
    if (live) chk("R11", irq_o, |(m_ist & m_ien));
  end

  task automatic wr_op(bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_op(bit [7:0] a, output bit [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = $urandom;
    #1;
    chk("R2", bus_ready, 1'b1);
    chk(tag_of(a), bus_rdata, m_read(a));
    v = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  task automatic idle(int k);
    bus_sel = 0; bus_wr = 0;
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit [31:0] v, v2;
    void'($urandom(32'h5eed_71e5));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1: reset state
    chk("R1", irq_o, 1'b0);
    foreach (v2[i]) if (i < 5) begin
      rd_op(8'h00 + 8'(4 * i), v);      chk("R1", v, 0);
    end
    rd_op(8'h10, v); chk("R1", v, 0);
    rd_op(8'h3C, v); chk("R1", v, 0);

    // R2: unmapped holes read zero
    rd_op(8'h08, v); chk("R2", v, 0);
    rd_op(8'h12, v); chk("R2", v, 0);

    // R12 + R3: channel 1 free-running from all ones
    wr_op(8'h34, 32'hFFFF_FFFF);
    wr_op(8'h38, 32'hFFFF_FFFF);
    wr_op(8'h30, 32'h0000_0003);
    idle(3);
    rd_op(8'h30, v); chk("R3", v, 32'h1);
    rd_op(8'h3C, v);
    idle(2);
    rd_op(8'h3C, v2);
    chk("R12", v2 < v, 1'b1);

    // R7 + R9 + R11: one-shot on channel 0 with interrupt enabled
    wr_op(8'h00, 32'h1);
    wr_op(8'h14, 32'd3);
    wr_op(8'h10, 32'h83);
    idle(8);
    rd_op(8'h10, v); chk("R7", v, 32'h80);
    rd_op(8'h1C, v); chk("R7", v, 0);
    rd_op(8'h04, v); chk("R9", v[0], 1'b1);
    chk("R11", irq_o, 1'b1);
    wr_op(8'h04, 32'h0);
    rd_op(8'h04, v); chk("R9", v[0], 1'b1);
    wr_op(8'h04, 32'h1);
    rd_op(8'h04, v); chk("R9", v[0], 1'b0);
    chk("R11", irq_o, 1'b0);

    // R9 + R6: periodic expiries with interrupt masked
    wr_op(8'h00, 32'h0);
    wr_op(8'h14, 32'd2);
    wr_op(8'h10, 32'h03);
    idle(10);
    rd_op(8'h04, v); chk("R9", v[0], 1'b1);
    chk("R11", irq_o, 1'b0);
    rd_op(8'h1C, v); chk("R6", v <= 2, 1'b1);

    // R8: disable freezes, resume continues
    wr_op(8'h14, 32'd100);
    wr_op(8'h10, 32'h03);
    idle(5);
    wr_op(8'h10, 32'h00);
    rd_op(8'h1C, v);
    idle(5);
    rd_op(8'h1C, v2); chk("R8", v2, v);
    wr_op(8'h10, 32'h01);
    idle(4);
    rd_op(8'h1C, v2); chk("R8", v2 < v, 1'b1);

    // R5: divide by 4, read 8 cycles after the load
    wr_op(8'h14, 32'd10);
    wr_op(8'h10, 32'h23);
    idle(8);
    rd_op(8'h1C, v); chk("R5", v, 32'd8);

    // R10: zero interval expires every cycle, clear collides
    wr_op(8'h14, 32'd0);
    wr_op(8'h10, 32'h03);
    idle(2);
    wr_op(8'h04, 32'h1);
    rd_op(8'h04, v); chk("R10", v[0], 1'b1);
    wr_op(8'h10, 32'h00);
    wr_op(8'h04, 32'h3);
    rd_op(8'h04, v); chk("R9", v[0], 1'b0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      int ch;
      bit [7:0] b;
      op = $urandom_range(0, 9);
      ch = $urandom_range(0, NCH - 1);
      b  = chb(ch);
      case (op)
        0, 1: wr_op(b, {24'd0, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 2)),
                        2'b00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0)});
        2:    wr_op(b + 8'd4, 32'($urandom_range(0, 30)));
        3:    wr_op(b + 8'd8, ($urandom_range(0, 15) == 0) ? 32'd1 : 32'd0);
        4:    wr_op(8'h00, 32'($urandom_range(0, 3)));
        5:    wr_op(8'h04, 32'($urandom_range(0, 3)));
        6, 7: rd_op(8'(4 * $urandom_range(0, 19)), v);
        8:    rd_op(b + 8'd12, v);
        default: idle($urandom_range(1, 5));
      endcase
    end

    idle(2);
    live = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule